// File: doc/BRIEF.md
# PLL Bandwidth-Mode Lock Qualifier

This block chooses whether a clock PLL runs with its loop in wide or narrow bandwidth. Narrow bandwidth filters the reference well but acquires lock slowly. So, when the power-up override is enabled, the block keeps the loop wide until lock has been shown over a run of consecutive phase-detector comparisons. It then lowers the bandwidth by itself, with no outside action.

The phase detector presents a one-cycle strobe for each comparison, together with a loss-of-lock flag that is valid with that strobe. A lock-clean strobe extends the run. A strobe flagged as loss of lock empties the run. When the run reaches its length (eight by default), a sticky qualified flag is set. From then on, loss-of-lock events have no effect until a reset, or until the override enable is lowered and raised again. The narrow-bandwidth request only takes effect while the override is enabled and qualification is complete. With the override disabled, the loop is held wide.

Top module: `bwsel_qualifier`

## Requirements
- R1: After a clock edge with `rst` high, `bw_narrow` is 0 (wide bandwidth) and `qual_done` is 0, whatever the state before.
- R2: `bw_narrow` encodes 1 = narrow, 0 = wide. With `init_en` high, `qual_done` rises on the clock edge that samples the eighth consecutive `pd_strobe` with `lol_flag` low. After seven such strobes it is still 0.
- R3: A `pd_strobe` with `lol_flag` high, sampled before qualification completes (including on the eighth strobe), empties the run. Eight further clean strobes are then needed.
- R4: Only cycles with `pd_strobe` high take part in qualification. Cycles without a strobe neither advance nor empty the run, even when `lol_flag` is high.
- R5: `bw_narrow` is registered. With `init_en` and `nbw_req` high, it changes to 1 on the same clock edge that sets `qual_done`, which is one clock after the completing strobe is presented.
- R6: One clock after `init_en` is sampled low, `bw_narrow` and `qual_done` are 0 and the run is empty. Strobes are ignored while `init_en` stays low. After `init_en` is raised again, a fresh run of eight clean strobes is required.
- R7: One clock after `nbw_req` is sampled low, `bw_narrow` is 0. Qualification progresses regardless of `nbw_req`, so raising `nbw_req` after qualification gives `bw_narrow` = 1 on the next edge.
- R8: Once `qual_done` is 1 (with `init_en` held high), strobes flagged as loss of lock and any further clean strobes leave both `qual_done` and `bw_narrow` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | Power-up override enable. Low forces wide bandwidth |
| nbw_req | input | 1 | Narrow-bandwidth request |
| pd_strobe | input | 1 | One-cycle pulse per phase-detector comparison |
| lol_flag | input | 1 | Loss of lock, valid while `pd_strobe` is high |
| bw_narrow | output | 1 | Bandwidth select: 1 narrow, 0 wide |
| qual_done | output | 1 | Lock qualification complete (sticky) |

## Verification
The main function is exercised with several strobe patterns:
- A clean run of exactly eight strobes, separated by idle cycles that carry a stray loss-of-lock flag, shows that the threshold sits at eight and that cycles without a strobe are ignored.
- A run broken by loss of lock on its eighth strobe separates "reset the run" from "ignore the event", because only a full new run may then qualify.
- Holding the override low through a long clean run, and then dropping it after qualification, separates the forced-wide path from the qualified path.
- Toggling the narrow request before and after qualification separates the request gating from the sticky qualified state.

// File: rtl/bwsel_pkg.sv
package bwsel_pkg;
  typedef enum logic {
    BW_WIDE   = 1'b0,
    BW_NARROW = 1'b1
  } bw_mode_t;
endpackage

// File: rtl/lockrun_counter.sv
module lockrun_counter #(
  parameter int RUN_LEN = 8,
  localparam int CNT_W  = $clog2(RUN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic init_en,
  input  logic pd_strobe,
  input  logic lol_flag,
  output logic qual_nx,
  output logic qual_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] run_q, run_nx;

  always_comb begin
    run_nx  = run_q;
    qual_nx = qual_q;
    if (!init_en) begin
      run_nx  = '0;
      qual_nx = 1'b0;
    end else if (pd_strobe && !qual_q) begin
      if (lol_flag) begin
        run_nx = '0;
      end else begin
        run_nx = run_q + CNT_W'(1);
        if (run_q == LAST) qual_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      qual_q <= 1'b0;
    end else begin
      run_q  <= run_nx;
      qual_q <= qual_nx;
    end
  end

  // R3: loss of lock before completion cannot complete qualification
  a_r3_lol_blocks: assert property (@(posedge clk) disable iff (rst)
    (pd_strobe && lol_flag && !qual_q) |=> !qual_q);
  // R2: completion only follows a clean strobe with the override on
  a_r2_done_after_clean: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_q) |-> $past(pd_strobe && !lol_flag && init_en));
  // R8: qualified state is sticky while the override stays on
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (qual_q && init_en) |=> qual_q);
  // R2: run count never passes its length
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    run_q <= CNT_W'(RUN_LEN));
  // R4: no strobe, no change of run
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!pd_strobe && init_en) |=> $stable(run_q));
endmodule

// File: rtl/bwsel_decide.sv
module bwsel_decide
  import bwsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     init_en,
  input  logic     nbw_req,
  input  logic     qual_nx,
  output bw_mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (rst)                               mode_q <= BW_WIDE;
    else if (init_en && nbw_req && qual_nx) mode_q <= BW_NARROW;
    else                                   mode_q <= BW_WIDE;
  end

  // R6: override low forces wide on the next edge
  a_r6_init_low_wide: assert property (@(posedge clk) disable iff (rst)
    !init_en |=> (mode_q == BW_WIDE));
  // R7: no narrow request, wide on the next edge
  a_r7_no_req_wide: assert property (@(posedge clk) disable iff (rst)
    !nbw_req |=> (mode_q == BW_WIDE));
endmodule

// File: rtl/bwsel_qualifier.sv
module bwsel_qualifier
  import bwsel_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic init_en,
  input  logic nbw_req,
  input  logic pd_strobe,
  input  logic lol_flag,
  output logic bw_narrow,
  output logic qual_done
);
  logic     qual_nx, qual_q;
  bw_mode_t mode_q;

  lockrun_counter #(.RUN_LEN(RUN_LEN)) run_i (
    .clk(clk), .rst(rst), .init_en(init_en), .pd_strobe(pd_strobe),
    .lol_flag(lol_flag), .qual_nx(qual_nx), .qual_q(qual_q)
  );

  bwsel_decide dec_i (
    .clk(clk), .rst(rst), .init_en(init_en), .nbw_req(nbw_req),
    .qual_nx(qual_nx), .mode_q(mode_q)
  );

  assign bw_narrow = (mode_q == BW_NARROW);
  assign qual_done = qual_q;

  // R5: narrow only ever coexists with completed qualification
  a_r5_narrow_needs_done: assert property (@(posedge clk) disable iff (rst)
    bw_narrow |-> qual_done);
  // R1: reset leaves the loop wide and unqualified
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!bw_narrow && !qual_done));
endmodule

// File: tb/bwsel_qualifier_tb_top.sv
module bwsel_qualifier_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_en = 1'b0, nbw_req = 1'b0, pd_strobe = 1'b0, lol_flag = 1'b0;
  logic bw_narrow, qual_done;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwsel_qualifier #(.RUN_LEN(8)) dut_i (
    .clk(clk), .rst(rst), .init_en(init_en), .nbw_req(nbw_req),
    .pd_strobe(pd_strobe), .lol_flag(lol_flag),
    .bw_narrow(bw_narrow), .qual_done(qual_done)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one strobe; returns at the next falling edge, after the sampling edge
  task automatic pulse(logic lol);
    @(negedge clk); pd_strobe = 1'b1; lol_flag = lol;
    @(negedge clk); pd_strobe = 1'b0; lol_flag = 1'b0;
  endtask

  task automatic clean(int n);
    for (int i = 0; i < n; i++) pulse(1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    init_en = 1'b1; nbw_req = 1'b1;
    do_reset();
    chk("R1", "bw after reset", bw_narrow, 1'b0);
    chk("R1", "done after reset", qual_done, 1'b0);
  endtask

  task automatic t_exact_run();
    do_reset(); init_en = 1'b1; nbw_req = 1'b1;
    for (int i = 0; i < 7; i++) begin
      pulse(1'b0);
      @(negedge clk); lol_flag = 1'b1;   // R4: stray flag without strobe
      @(negedge clk); lol_flag = 1'b0;
    end
    chk("R2", "done after 7", qual_done, 1'b0);
    chk("R4", "idle lol ignored, bw", bw_narrow, 1'b0);
    pulse(1'b0);
    chk("R2", "done after 8", qual_done, 1'b1);
    chk("R5", "narrow with done", bw_narrow, 1'b1);
  endtask

  task automatic t_sticky();
    pulse(1'b1); pulse(1'b1); clean(3);
    chk("R8", "done after late lol", qual_done, 1'b1);
    chk("R8", "bw after late lol", bw_narrow, 1'b1);
  endtask

  task automatic t_lol_on_eighth();
    do_reset(); init_en = 1'b1; nbw_req = 1'b1;
    clean(7); pulse(1'b1);
    chk("R3", "done after lol on 8th", qual_done, 1'b0);
    clean(7);
    chk("R3", "done 7 after restart", qual_done, 1'b0);
    chk("R3", "bw 7 after restart", bw_narrow, 1'b0);
    pulse(1'b0);
    chk("R3", "done 8 after restart", qual_done, 1'b1);
    do_reset();
    chk("R1", "reset clears qualified done", qual_done, 1'b0);
    chk("R1", "reset clears narrow", bw_narrow, 1'b0);
  endtask

  task automatic t_init_low();
    do_reset(); init_en = 1'b0; nbw_req = 1'b1;
    clean(10);
    chk("R6", "bw with init low", bw_narrow, 1'b0);
    chk("R6", "done with init low", qual_done, 1'b0);
    @(negedge clk); init_en = 1'b1;
    clean(8);
    chk("R6", "done after raise+8", qual_done, 1'b1);
    @(negedge clk); init_en = 1'b0;
    @(negedge clk);
    chk("R6", "bw one clk after drop", bw_narrow, 1'b0);
    chk("R6", "done one clk after drop", qual_done, 1'b0);
    init_en = 1'b1;
    clean(7);
    chk("R6", "fresh run needed", qual_done, 1'b0);
    pulse(1'b0);
    chk("R6", "fresh run complete", bw_narrow, 1'b1);
  endtask

  task automatic t_nbw_low();
    do_reset(); init_en = 1'b1; nbw_req = 1'b0;
    clean(8);
    chk("R7", "done without request", qual_done, 1'b1);
    chk("R7", "bw without request", bw_narrow, 1'b0);
    @(negedge clk); nbw_req = 1'b1;
    @(negedge clk);
    chk("R7", "bw after request", bw_narrow, 1'b1);
    nbw_req = 1'b0;
    @(negedge clk);
    chk("R7", "bw after request drop", bw_narrow, 1'b0);
    init_en = 1'b0; nbw_req = 1'b1;
    @(negedge clk);
    chk("R6", "request with init low", bw_narrow, 1'b0);
  endtask

  initial begin
    t_reset();
    t_exact_run();
    t_sticky();
    t_lol_on_eighth();
    t_init_low();
    t_nbw_low();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule